// File: doc/BRIEF.md
# Reversible-Gate Magnitude Comparator

This block compares two unsigned operands and raises exactly one of three flags: equal, greater than, or less than. It has no clock and no state. Every internal operation is built from reversible primitive gates, each with as many outputs as inputs and a one-to-one mapping. The four primitives are a single-line inverter, a controlled inverter with a parameterised number of control lines, a three-line "copy, xor, and-not" gate, and a three-line "copy, copy, or" gate.

Each internal line feeds exactly one gate input. When a value is needed twice, the second copy is taken from the pass-through output of a gate that already used it, not from a wire split. Constant inputs are tied to zero inside the block. Every gate output that is not a flag leaves the block on a garbage bus, so the total line count is conserved: 2·WIDTH operand lines plus 3·WIDTH constants equal 3 flags plus 5·WIDTH−3 garbage lines.

Because the block is purely combinational, it has no stream handshake. A user drives the operands and reads the flags in the same cycle. The garbage bus may be left unconnected, or it may be used to run the circuit backwards.

Top module: `rev_mag_cmp`

## Requirements
- R1: `a_eq_o` is 1 exactly when `opa_i` equals `opb_i`; with both operands zero it reads 1.
- R2: `a_gt_o` is 1 exactly when `opa_i` is greater than `opb_i` as an unsigned number.
- R3: `a_lt_o` is 1 exactly when `opa_i` is less than `opb_i` as an unsigned number.
- R4: For every operand pair exactly one of `a_eq_o`, `a_gt_o`, `a_lt_o` is 1.
- R5: The inverter primitive maps its input bit to its complement, and this mapping is a bijection over both input values.
- R6: The controlled inverter passes its control lines through unchanged. Its target output is the target input xor the AND of all controls. The mapping is a bijection over all control and target combinations.
- R7: The first three-line gate maps (a,b,c) to (a, a xor b, (a and not b) xor c), and this mapping is a bijection over all 8 inputs.
- R8: The second three-line gate maps (a,b,c) to (a, b, (a or b) xor c), and this mapping is a bijection over all 8 inputs.
- R9: Bits [WIDTH-1:0] of `garbage_o` carry an unchanged copy of `opa_i`, with bit i taken from the gate that handles operand bit i.
- R10: The whole block is injective. No two distinct operand pairs produce the same value of {flags, `garbage_o`}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | WIDTH | First unsigned operand |
| opb_i | input | WIDTH | Second unsigned operand |
| a_eq_o | output | 1 | Operands are equal |
| a_gt_o | output | 1 | First operand is greater |
| a_lt_o | output | 1 | First operand is smaller |
| garbage_o | output | 5*WIDTH-3 | Non-flag gate outputs, low WIDTH bits are the first operand |

## Verification
On every evaluation the assertions check four things. Each primitive's outputs must let its inputs be recovered. The flags must match an arithmetic compare, exactly one flag must be high, and the low garbage bits must echo the first operand. Two properties cover whole domains and so can only be shown by the bench's scenarios. The first is that each primitive is a bijection over its full input domain. The second is that the block maps all operand pairs to distinct output vectors, which the bench confirms by comparing every pair of recorded results.

// File: rtl/rcmp_pkg.sv
package rcmp_pkg;
  // Lines left over after the three flags: per-bit operand copies,
  // product-gate control copies, equality-gate controls, OR-chain pass-throughs.
  function automatic int garbage_lines(input int w);
    return 5 * w - 3;
  endfunction
endpackage

// File: rtl/rcmp_inv.sv
module rcmp_inv (
  input  logic a_i,
  output logic y_o
);
  assign y_o = ~a_i;

  always_comb begin
    assert_inv_recover_R5: assert (a_i == ~y_o)
      else $error("inverter input not recoverable");
  end
endmodule

// File: rtl/rcmp_ctl_inv.sv
module rcmp_ctl_inv #(
  parameter int NCTL = 2
) (
  input  logic [NCTL-1:0] ctl_i,
  input  logic            tgt_i,
  output logic [NCTL-1:0] ctl_o,
  output logic            tgt_o
);
  assign ctl_o = ctl_i;
  assign tgt_o = tgt_i ^ (&ctl_i);

  always_comb begin
    assert_ctl_pass_R6: assert (ctl_o == ctl_i)
      else $error("control lines altered");
    assert_ctl_recover_R6: assert (tgt_i == (tgt_o ^ (&ctl_o)))
      else $error("target not recoverable");
  end
endmodule

// File: rtl/rcmp_xand.sv
module rcmp_xand (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic p_o,
  output logic q_o,
  output logic r_o
);
  assign p_o = a_i;
  assign q_o = a_i ^ b_i;
  assign r_o = (a_i & ~b_i) ^ c_i;

  always_comb begin
    assert_xand_recover_R7: assert ({a_i, b_i, c_i} ==
        {p_o, p_o ^ q_o, r_o ^ (p_o & q_o)})
      else $error("xand inputs not recoverable");
  end
endmodule

// File: rtl/rcmp_orx.sv
module rcmp_orx (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic p_o,
  output logic q_o,
  output logic r_o
);
  assign p_o = a_i;
  assign q_o = b_i;
  assign r_o = (a_i | b_i) ^ c_i;

  always_comb begin
    assert_orx_recover_R8: assert ({a_i, b_i, c_i} == {p_o, q_o, r_o ^ (p_o | q_o)})
      else $error("orx inputs not recoverable");
  end
endmodule

// File: rtl/rev_mag_cmp.sv
module rev_mag_cmp #(
  parameter int WIDTH = 4,
  localparam int GW = rcmp_pkg::garbage_lines(WIDTH)
) (
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  output logic             a_eq_o,
  output logic             a_gt_o,
  output logic             a_lt_o,
  output logic [GW-1:0]    garbage_o
);
  localparam int OFS_GCOPY = WIDTH;              // WIDTH-1 lines
  localparam int OFS_EQCTL = 2 * WIDTH - 1;      // WIDTH lines
  localparam int OFS_ORCH  = 3 * WIDTH - 1;      // 2*(WIDTH-1) lines

  logic [WIDTH-1:0] diff;   // a xor b per bit
  logic [WIDTH-1:0] xeq;    // per-bit equality
  logic [WIDTH-1:0] agtb;   // a and not b per bit
  logic [WIDTH-1:0] term;   // greater-than product terms
  logic [WIDTH-1:0] acc;    // OR-chain accumulator
  logic             eq_raw;
  logic             lt_or;

  // Per-bit front end: xand gate with tied constant, then inverter.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    rcmp_xand u_xand (
      .a_i(opa_i[i]), .b_i(opb_i[i]), .c_i(1'b0),
      .p_o(garbage_o[i]), .q_o(diff[i]), .r_o(agtb[i])
    );
    rcmp_inv u_inv (.a_i(diff[i]), .y_o(xeq[i]));
  end

  // Top product term needs no gate.
  assign term[WIDTH-1] = agtb[WIDTH-1];

  // Product stages: stage k forms x[W-1..k+1]·agtb[k]; equality lines pass
  // through each stage's controls and carry on to the next stage.
  for (genvar k = WIDTH - 2; k >= 0; k--) begin : g_prod
    localparam int NX = WIDTH - 1 - k;
    logic [NX-1:0] xin;
    logic [NX-1:0] xout;
    if (k == WIDTH - 2) begin : g_first
      assign xin = xeq[WIDTH-1];
    end else begin : g_next
      assign xin = {g_prod[k+1].xout, xeq[k+1]};
    end
    rcmp_ctl_inv #(.NCTL(NX + 1)) u_and (
      .ctl_i({xin, agtb[k]}), .tgt_i(1'b0),
      .ctl_o({xout, garbage_o[OFS_GCOPY+k]}), .tgt_o(term[k])
    );
  end

  // Equality: AND of all per-bit equality lines.
  rcmp_ctl_inv #(.NCTL(WIDTH)) u_eq (
    .ctl_i({g_prod[0].xout, xeq[0]}), .tgt_i(1'b0),
    .ctl_o(garbage_o[OFS_EQCTL +: WIDTH]), .tgt_o(eq_raw)
  );

  // OR chain over product terms.
  assign acc[WIDTH-1] = term[WIDTH-1];
  for (genvar k = WIDTH - 2; k >= 0; k--) begin : g_or
    rcmp_orx u_or (
      .a_i(acc[k+1]), .b_i(term[k]), .c_i(1'b0),
      .p_o(garbage_o[OFS_ORCH+2*k]), .q_o(garbage_o[OFS_ORCH+2*k+1]),
      .r_o(acc[k])
    );
  end

  // Less-than: not (gt or eq); the gate's pass-throughs provide the flags.
  rcmp_orx u_ltor (
    .a_i(acc[0]), .b_i(eq_raw), .c_i(1'b0),
    .p_o(a_gt_o), .q_o(a_eq_o), .r_o(lt_or)
  );
  rcmp_inv u_ltinv (.a_i(lt_or), .y_o(a_lt_o));

  always_comb begin
    assert_eq_flag_R1: assert (a_eq_o == (opa_i == opb_i))
      else $error("equal flag wrong");
    assert_gt_flag_R2: assert (a_gt_o == (opa_i > opb_i))
      else $error("greater flag wrong");
    assert_lt_flag_R3: assert (a_lt_o == (opa_i < opb_i))
      else $error("less flag wrong");
    assert_flags_onehot_R4: assert ($onehot({a_eq_o, a_gt_o, a_lt_o}))
      else $error("flags not one-hot");
    assert_opa_copy_R9: assert (garbage_o[WIDTH-1:0] == opa_i)
      else $error("operand copy lost");
  end
endmodule

// File: tb/tb_rev_mag_cmp.sv
module tb_rev_mag_cmp;
  localparam int W  = 4;
  localparam int GW = 5 * W - 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [W-1:0] opa, opb;
  logic eq, gt, lt;
  logic [GW-1:0] garb;

  rev_mag_cmp #(.WIDTH(W)) dut (
    .opa_i(opa), .opb_i(opb), .a_eq_o(eq), .a_gt_o(gt), .a_lt_o(lt),
    .garbage_o(garb)
  );

  // Standalone primitives
  logic inv_a, inv_y;
  rcmp_inv u_inv (.a_i(inv_a), .y_o(inv_y));
  logic [2:0] ci_c, ci_co;
  logic ci_t, ci_to;
  rcmp_ctl_inv #(.NCTL(3)) u_ci (.ctl_i(ci_c), .tgt_i(ci_t), .ctl_o(ci_co), .tgt_o(ci_to));
  logic xa, xb, xc, xp, xq, xr;
  rcmp_xand u_xa (.a_i(xa), .b_i(xb), .c_i(xc), .p_o(xp), .q_o(xq), .r_o(xr));
  logic oa, ob, oc, op, oq, orr;
  rcmp_orx u_or (.a_i(oa), .b_i(ob), .c_i(oc), .p_o(op), .q_o(oq), .r_o(orr));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    summary();
  end

  logic [GW+2:0] sig [256];

  initial begin
    bit seen2 [2];
    bit seen16 [16];
    bit seen8 [8];
    int dup;
    opa = '0; opb = '0;
    inv_a = 0; ci_c = '0; ci_t = 0;
    xa = 0; xb = 0; xc = 0; oa = 0; ob = 0; oc = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: zero operands read equal
    chk(eq == 1'b1 && gt == 1'b0 && lt == 1'b0, "R1 start", {eq, gt, lt}, 3'b100);

    // R5: inverter
    dup = 0;
    for (int v = 0; v < 2; v++) seen2[v] = 0;
    for (int v = 0; v < 2; v++) begin
      @(posedge clk); #1 inv_a = v[0];
      @(negedge clk);
      chk(inv_y == ~v[0], "R5 map", inv_y, ~v[0]);
      if (seen2[inv_y]) dup++;
      seen2[inv_y] = 1;
    end
    chk(dup == 0, "R5 bijective", dup, 0);

    // R6: controlled inverter, 3 controls
    dup = 0;
    for (int v = 0; v < 16; v++) seen16[v] = 0;
    for (int v = 0; v < 16; v++) begin
      @(posedge clk); #1 {ci_c, ci_t} = v[3:0];
      @(negedge clk);
      chk(ci_co == v[3:1] && ci_to == (v[0] ^ (v[3:1] == 3'b111)), "R6 map",
          {ci_co, ci_to}, {v[3:1], v[0] ^ (v[3:1] == 3'b111)});
      if (seen16[{ci_co, ci_to}]) dup++;
      seen16[{ci_co, ci_to}] = 1;
    end
    chk(dup == 0, "R6 bijective", dup, 0);

    // R7: first three-line gate
    dup = 0;
    for (int v = 0; v < 8; v++) seen8[v] = 0;
    for (int v = 0; v < 8; v++) begin
      logic ea, eb, ec;
      {ea, eb, ec} = v[2:0];
      @(posedge clk); #1 {xa, xb, xc} = v[2:0];
      @(negedge clk);
      chk({xp, xq, xr} == {ea, ea ^ eb, (ea & ~eb) ^ ec}, "R7 map",
          {xp, xq, xr}, {ea, ea ^ eb, (ea & ~eb) ^ ec});
      if (seen8[{xp, xq, xr}]) dup++;
      seen8[{xp, xq, xr}] = 1;
    end
    chk(dup == 0, "R7 bijective", dup, 0);

    // R8: second three-line gate
    dup = 0;
    for (int v = 0; v < 8; v++) seen8[v] = 0;
    for (int v = 0; v < 8; v++) begin
      logic ea, eb, ec;
      {ea, eb, ec} = v[2:0];
      @(posedge clk); #1 {oa, ob, oc} = v[2:0];
      @(negedge clk);
      chk({op, oq, orr} == {ea, eb, (ea | eb) ^ ec}, "R8 map",
          {op, oq, orr}, {ea, eb, (ea | eb) ^ ec});
      if (seen8[{op, oq, orr}]) dup++;
      seen8[{op, oq, orr}] = 1;
    end
    chk(dup == 0, "R8 bijective", dup, 0);

    // R1..R4, R9: all operand pairs
    for (int ia = 0; ia < 16; ia++) begin
      for (int ib = 0; ib < 16; ib++) begin
        @(posedge clk); #1 opa = ia[3:0]; opb = ib[3:0];
        @(negedge clk);
        chk(eq == (ia == ib), "R1 eq", eq, ia == ib);
        chk(gt == (ia > ib), "R2 gt", gt, ia > ib);
        chk(lt == (ia < ib), "R3 lt", lt, ia < ib);
        chk(eq + gt + lt == 1, "R4 onehot", eq + gt + lt, 1);
        chk(garb[W-1:0] == ia[3:0], "R9 copy", garb[W-1:0], ia);
        sig[ia * 16 + ib] = {eq, gt, lt, garb};
      end
    end

    // R10: injectivity over the whole domain
    dup = 0;
    for (int i = 0; i < 256; i++)
      for (int j = i + 1; j < 256; j++)
        if (sig[i] == sig[j]) dup++;
    chk(dup == 0, "R10 injective", dup, 0);

    summary();
  end
endmodule